// File: doc/BRIEF.md
# Memory Refresh Counter with Opcode-Fetch Classification

This block keeps the refresh register of an 8-bit processor core. It watches the bytes arriving from the opcode fetch path, decides which of them open a first machine cycle (M1), and advances the register once for every such cycle. The low seven bits count and wrap. The top bit changes only through a software load or a reset. Prefix bytes open their own M1 cycle. After an index prefix followed by the bit-operation prefix, the displacement byte and the final opcode byte are not M1 cycles, even when they arrive in an opcode slot.

After each M1 the block emits a one-cycle pulse. One cycle after the pulse it drives a refresh address and asserts an active-low refresh strobe for exactly one cycle. The address carries the interrupt-vector register in its high byte and the freshly advanced refresh register in its low byte. The core loads both registers from the accumulator through write ports, and it reads the refresh register from `r_value`.

Top module: `mem_refresh_unit`

## Requirements
- R1: After reset, `r_value` is 0x00, `refresh_addr` is 0x0000, `refresh_strobe_n` is 1 and `m1_pulse` is 0.
- R2: Each M1 cycle adds one to `r_value[6:0]`, wrapping from 0x7F to 0x00, and leaves `r_value[7]` unchanged. For example, 0x7F goes to 0x00 and 0xFF goes to 0x80.
- R3: A load (`ld_r_we`=1) writes all 8 bits of `ld_r_data`. When a load coincides with an M1 fetch, the loaded value is kept and is not incremented.
- R4: A valid byte with `fetch_is_opcode_slot`=1 in the idle context is one M1 cycle. A valid byte with `fetch_is_opcode_slot`=0 adds nothing.
- R5: The prefixes 0xED and 0xCB each count as an M1 cycle, and so does the opcode byte that follows either of them. A prefixed instruction therefore adds 2.
- R6: An index prefix (0xDD or 0xFD) followed by 0xCB adds 2. The next two valid bytes (displacement, then opcode) add nothing, whatever their slot flag.
- R7: An index prefix followed by another prefix byte counts as one M1 on its own, and the following byte is classified afresh. For example, DD DD 21 adds 3 and FD ED 44 adds 3.
- R8: A repeated instruction that refetches its opcode bytes adds the full M1 count again on each pass.
- R9: `m1_pulse` is 1 for exactly the one cycle after the clock edge that records an M1 fetch, and is 1 once per M1.
- R10: `refresh_strobe_n` is 0 for exactly the one cycle after each `m1_pulse` cycle. During that cycle `refresh_addr` equals {I, R}, where R is the value `r_value` showed in the pulse cycle.
- R11: `ld_i_we`=1 loads `ld_i_data` into the I register, which appears on `refresh_addr[15:8]` at the next refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A byte from the instruction stream is present |
| fetch_byte | input | 8 | The fetched byte |
| fetch_is_opcode_slot | input | 1 | The byte was read in an opcode position, not as an operand |
| ld_r_we | input | 1 | Load refresh register from accumulator |
| ld_r_data | input | 8 | Value to load into the refresh register |
| ld_i_we | input | 1 | Load interrupt-vector register |
| ld_i_data | input | 8 | Value to load into the interrupt-vector register |
| r_value | output | 8 | Current refresh register |
| refresh_addr | output | 16 | Refresh address {I, R} |
| refresh_strobe_n | output | 1 | Active-low refresh strobe |
| m1_pulse | output | 1 | One-cycle pulse per M1 cycle |

## Verification
An M1 byte presented before clock edge t changes `r_value` and raises `m1_pulse` after edge t. The strobe and the refresh address follow one edge later, at t+1, and the strobe clears at t+2. Inputs are driven just after a falling edge. Each result is sampled at the falling edge whose preceding rising edge is the one that produces it, so the pulse is checked one half-cycle after the capturing edge and the strobe a full cycle after that. The counting tests compare `r_value` against counts worked out by hand for each byte sequence, and the back-to-back test counts strobe cycles against the number of M1 bytes fed.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] PFX_EXT = 8'hED;
    localparam logic [BYTE_W-1:0] PFX_BIT = 8'hCB;
    localparam logic [BYTE_W-1:0] PFX_IX  = 8'hDD;
    localparam logic [BYTE_W-1:0] PFX_IY  = 8'hFD;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_EXT,
        PS_BIT,
        PS_IDX,
        PS_IDX_DISP,
        PS_IDX_OP
    } pfx_state_e;

    // Context entered after an M1 byte seen where a fresh opcode may start.
    function automatic pfx_state_e classify_lead(input logic [BYTE_W-1:0] b);
        if (b == PFX_EXT)                   return PS_EXT;
        else if (b == PFX_BIT)              return PS_BIT;
        else if (b == PFX_IX || b == PFX_IY) return PS_IDX;
        else                                return PS_IDLE;
    endfunction
endpackage

// File: rtl/rfsh_prefix_tracker.sv
module rfsh_prefix_tracker
    import rfsh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [BYTE_W-1:0] fetch_byte,
    input  logic              fetch_is_opcode_slot,
    output logic              is_m1
);
    typedef struct packed {
        pfx_state_e st;
    } trk_t;

    trk_t cur_q, nxt_d;
    logic m1_d;

    always_comb begin
        nxt_d = cur_q;
        m1_d  = 1'b0;
        if (fetch_valid) begin
            case (cur_q.st)
                PS_IDX_DISP: nxt_d.st = PS_IDX_OP;
                PS_IDX_OP:   nxt_d.st = PS_IDLE;
                default: begin
                    if (fetch_is_opcode_slot) begin
                        m1_d = 1'b1;
                        case (cur_q.st)
                            PS_IDLE: nxt_d.st = classify_lead(fetch_byte);
                            PS_IDX:  nxt_d.st = (fetch_byte == PFX_BIT) ? PS_IDX_DISP
                                                                        : classify_lead(fetch_byte);
                            default: nxt_d.st = PS_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '{st: PS_IDLE};
        else        cur_q <= nxt_d;
    end

    assign is_m1 = m1_d;

    // R6
    idx_bit_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_is_opcode_slot && cur_q.st == PS_IDX && fetch_byte == PFX_BIT)
        |=> (cur_q.st == PS_IDX_DISP));

    // R6
    idx_bit_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && cur_q.st == PS_IDX_DISP) |=> (cur_q.st == PS_IDX_OP));

    // R5
    ext_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_is_opcode_slot && (cur_q.st == PS_EXT || cur_q.st == PS_BIT))
        |=> (cur_q.st == PS_IDLE));
endmodule

// File: rtl/rfsh_reg_file.sv
module rfsh_reg_file #(
    parameter int CNT_W = 7,
    localparam int REG_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             m1,
    input  logic             ld_r_we,
    input  logic [REG_W-1:0] ld_r_data,
    input  logic             ld_i_we,
    input  logic [REG_W-1:0] ld_i_data,
    output logic [REG_W-1:0] r_q_o,
    output logic [REG_W-1:0] i_q_o,
    output logic             pulse_q_o
);
    typedef struct packed {
        logic [REG_W-1:0] r;
        logic [REG_W-1:0] i;
        logic             pulse;
    } regs_t;

    regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.pulse = m1;
        if (ld_r_we)
            nxt_d.r = ld_r_data;
        else if (m1)
            nxt_d.r = {cur_q.r[REG_W-1], cur_q.r[CNT_W-1:0] + {{(CNT_W-1){1'b0}}, 1'b1}};
        if (ld_i_we)
            nxt_d.i = ld_i_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign r_q_o     = cur_q.r;
    assign i_q_o     = cur_q.i;
    assign pulse_q_o = cur_q.pulse;

    // R2
    top_bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_r_we |=> (cur_q.r[REG_W-1] == $past(cur_q.r[REG_W-1])));

    // R2
    low_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m1 && !ld_r_we) |=> (cur_q.r[CNT_W-1:0] == CNT_W'($past(cur_q.r[CNT_W-1:0]) + 1)));

    // R3
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_r_we |=> (cur_q.r == $past(ld_r_data)));
endmodule

// File: rtl/rfsh_addr_gen.sv
module rfsh_addr_gen #(
    parameter int REG_W = 8,
    localparam int ADDR_W = 2 * REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse,
    input  logic [REG_W-1:0]  r_val,
    input  logic [REG_W-1:0]  i_val,
    output logic [ADDR_W-1:0] addr_o,
    output logic              strobe_n_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              strobe_n;
    } out_t;

    out_t cur_q, nxt_d;

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.strobe_n = ~pulse;
        if (pulse)
            nxt_d.addr = {i_val, r_val};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '{addr: '0, strobe_n: 1'b1};
        else        cur_q <= nxt_d;
    end

    assign addr_o     = cur_q.addr;
    assign strobe_n_o = cur_q.strobe_n;

    // R10
    strobe_follows_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> (!cur_q.strobe_n && cur_q.addr[REG_W-1:0] == $past(r_val)));

    // R10
    strobe_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse |=> cur_q.strobe_n);
endmodule

// File: rtl/mem_refresh_unit.sv
module mem_refresh_unit #(
    parameter int CNT_W = 7,
    localparam int REG_W = CNT_W + 1,
    localparam int ADDR_W = 2 * REG_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fetch_valid,
    input  logic [rfsh_pkg::BYTE_W-1:0] fetch_byte,
    input  logic                       fetch_is_opcode_slot,
    input  logic                       ld_r_we,
    input  logic [REG_W-1:0]           ld_r_data,
    input  logic                       ld_i_we,
    input  logic [REG_W-1:0]           ld_i_data,
    output logic [REG_W-1:0]           r_value,
    output logic [ADDR_W-1:0]          refresh_addr,
    output logic                       refresh_strobe_n,
    output logic                       m1_pulse
);
    logic             m1;
    logic [REG_W-1:0] i_val;

    rfsh_prefix_tracker u_trk (
        .clk                  (clk),
        .rst_n                (rst_n),
        .fetch_valid          (fetch_valid),
        .fetch_byte           (fetch_byte),
        .fetch_is_opcode_slot (fetch_is_opcode_slot),
        .is_m1                (m1)
    );

    rfsh_reg_file #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .m1        (m1),
        .ld_r_we   (ld_r_we),
        .ld_r_data (ld_r_data),
        .ld_i_we   (ld_i_we),
        .ld_i_data (ld_i_data),
        .r_q_o     (r_value),
        .i_q_o     (i_val),
        .pulse_q_o (m1_pulse)
    );

    rfsh_addr_gen #(.REG_W(REG_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse      (m1_pulse),
        .r_val      (r_value),
        .i_val      (i_val),
        .addr_o     (refresh_addr),
        .strobe_n_o (refresh_strobe_n)
    );

    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !fetch_is_opcode_slot && !ld_r_we) |=> ($stable(r_value) && !m1_pulse));
endmodule

// File: tb/tb_mem_refresh_unit.sv
module tb_mem_refresh_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [7:0]  fetch_byte = 8'h00;
    logic        fetch_is_opcode_slot = 1'b0;
    logic        ld_r_we = 1'b0;
    logic [7:0]  ld_r_data = 8'h00;
    logic        ld_i_we = 1'b0;
    logic [7:0]  ld_i_data = 8'h00;
    logic [7:0]  r_value;
    logic [15:0] refresh_addr;
    logic        refresh_strobe_n;
    logic        m1_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mem_refresh_unit dut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_byte(fetch_byte),
        .fetch_is_opcode_slot(fetch_is_opcode_slot), .ld_r_we(ld_r_we), .ld_r_data(ld_r_data),
        .ld_i_we(ld_i_we), .ld_i_data(ld_i_data), .r_value(r_value), .refresh_addr(refresh_addr),
        .refresh_strobe_n(refresh_strobe_n), .m1_pulse(m1_pulse)
    );

    task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drives one cycle of inputs from a falling edge; returns at the next falling edge.
    task automatic step(input logic fv, input logic [7:0] b, input logic slot,
                        input logic rwe, input logic [7:0] rd);
        fetch_valid = fv; fetch_byte = b; fetch_is_opcode_slot = slot;
        ld_r_we = rwe; ld_r_data = rd;
        @(negedge clk);
        fetch_valid = 1'b0; fetch_is_opcode_slot = 1'b0; ld_r_we = 1'b0;
    endtask

    task automatic feed(input logic [7:0] b, input logic slot);
        step(1'b1, b, slot, 1'b0, 8'h00);
    endtask

    task automatic load_r(input logic [7:0] v);
        step(1'b0, 8'h00, 1'b0, 1'b1, v);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1", "r_value", 16'(r_value), 16'h00);
        check("R1", "refresh_addr", refresh_addr, 16'h0000);
        check("R1", "strobe_n", 16'(refresh_strobe_n), 16'h1);
        check("R1", "m1_pulse", 16'(m1_pulse), 16'h0);
    endtask

    task automatic t_single_and_refresh;
        ld_i_we = 1'b1; ld_i_data = 8'h3C;
        @(negedge clk);
        ld_i_we = 1'b0;
        load_r(8'h00);
        feed(8'h00, 1'b1);
        check("R4", "r after plain opcode", 16'(r_value), 16'h01);
        check("R9", "pulse in cycle after fetch", 16'(m1_pulse), 16'h1);
        check("R10", "strobe not yet low", 16'(refresh_strobe_n), 16'h1);
        @(negedge clk);
        check("R9", "pulse lasts one cycle", 16'(m1_pulse), 16'h0);
        check("R10", "strobe low", 16'(refresh_strobe_n), 16'h0);
        check("R11", "refresh address {I,R}", refresh_addr, 16'h3C01);
        @(negedge clk);
        check("R10", "strobe one cycle", 16'(refresh_strobe_n), 16'h1);
    endtask

    task automatic t_operand;
        load_r(8'h20);
        feed(8'h3E, 1'b1);
        feed(8'h55, 1'b0);
        check("R4", "operand byte ignored", 16'(r_value), 16'h21);
        check("R4", "no pulse for operand", 16'(m1_pulse), 16'h0);
        idle(2);
        check("R4", "no strobe for operand", 16'(refresh_strobe_n), 16'h1);
    endtask

    task automatic t_prefixes;
        load_r(8'h10);
        feed(8'hED, 1'b1); feed(8'h44, 1'b1);
        check("R5", "ED prefix adds 2", 16'(r_value), 16'h12);
        feed(8'hCB, 1'b1); feed(8'h07, 1'b1);
        check("R5", "CB prefix adds 2", 16'(r_value), 16'h14);
    endtask

    task automatic t_index_bit;
        load_r(8'h30);
        feed(8'hDD, 1'b1); feed(8'hCB, 1'b1); feed(8'h05, 1'b1); feed(8'h06, 1'b1);
        check("R6", "DD CB d op adds 2", 16'(r_value), 16'h32);
        feed(8'hFD, 1'b1); feed(8'hCB, 1'b1); feed(8'h7F, 1'b0); feed(8'h46, 1'b1);
        check("R6", "FD CB d op adds 2", 16'(r_value), 16'h34);
        feed(8'h00, 1'b1);
        check("R6", "context returns to idle", 16'(r_value), 16'h35);
    endtask

    task automatic t_stray;
        load_r(8'h40);
        feed(8'hDD, 1'b1); feed(8'hDD, 1'b1); feed(8'h21, 1'b1);
        check("R7", "DD DD 21 adds 3", 16'(r_value), 16'h43);
        feed(8'hFD, 1'b1); feed(8'hED, 1'b1); feed(8'h44, 1'b1);
        check("R7", "FD ED 44 adds 3", 16'(r_value), 16'h46);
    endtask

    task automatic t_wrap;
        load_r(8'h7E);
        feed(8'h00, 1'b1);
        check("R2", "0x7E+1", 16'(r_value), 16'h7F);
        feed(8'h00, 1'b1);
        check("R2", "0x7F wraps", 16'(r_value), 16'h00);
        load_r(8'hFF);
        check("R3", "load all 8 bits", 16'(r_value), 16'hFF);
        feed(8'h00, 1'b1);
        check("R2", "0xFF wraps keeping bit7", 16'(r_value), 16'h80);
        load_r(8'h85);
        feed(8'h00, 1'b1); feed(8'h00, 1'b1); feed(8'h00, 1'b1);
        check("R2", "bit7 held over counting", 16'(r_value), 16'h88);
    endtask

    task automatic t_collision;
        load_r(8'h50);
        step(1'b1, 8'h00, 1'b1, 1'b1, 8'h9A);
        check("R3", "load wins over M1", 16'(r_value), 16'h9A);
        feed(8'h00, 1'b1);
        check("R3", "counts from loaded value", 16'(r_value), 16'h9B);
    endtask

    task automatic t_repeat;
        load_r(8'h60);
        for (int k = 0; k < 3; k++) begin
            feed(8'hED, 1'b1); feed(8'hB0, 1'b1);
        end
        check("R8", "three refetched passes add 6", 16'(r_value), 16'h66);
    endtask

    task automatic t_back_to_back;
        int strobes = 0;
        int pulses = 0;
        load_r(8'h00);
        idle(2);
        fetch_valid = 1'b1; fetch_is_opcode_slot = 1'b1; fetch_byte = 8'h00;
        @(negedge clk);
        pulses += m1_pulse;
        fetch_byte = 8'h01;
        @(negedge clk);
        pulses += m1_pulse;
        strobes += !refresh_strobe_n;
        check("R10", "first address", refresh_addr, 16'h3C01);
        fetch_valid = 1'b0; fetch_is_opcode_slot = 1'b0;
        @(negedge clk);
        pulses += m1_pulse;
        strobes += !refresh_strobe_n;
        check("R10", "second address", refresh_addr, 16'h3C02);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            pulses += m1_pulse;
            strobes += !refresh_strobe_n;
        end
        check("R9", "one pulse per M1", 16'(pulses), 16'd2);
        check("R10", "one strobe cycle per M1", 16'(strobes), 16'd2);
    endtask

    initial begin
        fork
            begin
                #4_000_000;
                if (!done) begin
                    checks++; failures++;
                    $display("FAIL watchdog: actual=timeout expected=completion");
                    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                    $finish;
                end
            end
        join_none
        idle(3);
        @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_single_and_refresh;
        t_operand;
        t_prefixes;
        t_index_bit;
        t_stray;
        t_wrap;
        t_collision;
        t_repeat;
        t_back_to_back;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule